// File: doc/BRIEF.md
# Two-Stage Half-Band Decimator

This block lowpass-filters a stream of signed samples and halves its rate. The filter is sixth order, built from two identical third-order half-band lattice wave sections in cascade. In each section the two outer adaptor coefficients are zero, so those adaptors are plain wires. The remaining adaptor has coefficient one half, which reduces to an arithmetic shift. Every feedback loop holds two sample delays. Even-indexed and odd-indexed samples therefore never mix inside a section's recursive part.

The first section runs at the full input rate. The second section is folded into the decimation. It runs its recursive part only on even-indexed samples and emits one result per even input. The odd-indexed result of the first section feeds only the direct one-sample branch of that even result.

Samples enter with a valid strobe and may arrive with any gaps. Indexing starts at zero after reset. Each section is a three-stage pipeline, so the total latency is fixed in clock edges.

Top module: `hb_decim_top`

## Requirements
- R1: While rst_ni is low, valid_o and data_o are zero and all delay state is cleared; the sample index restarts at zero when reset is released.
- R2: For each accepted input with an even index (0, 2, 4, … counted over accepted inputs since reset), valid_o is high for exactly one cycle, starting right after the sixth rising clock edge counted from the edge that accepted it. Inputs with an odd index produce no pulse.
- R3: A cycle with valid_i low is ignored: data_i has no effect, and neither the sample index nor any filter state moves.
- R4: First section, for every accepted sample x[n] with state s = q[n-2]: B1 = s + ((s − x[n]) >>> 1), q[n] = x[n] + ((s − x[n]) >>> 1), and y1[n] = (x[n-1] + B1) >>> 1 computed in W+1 bits. Values before the first sample are zero, and >>> rounds toward minus infinity.
- R5: B1 and q are kept in W bits and wrap modulo 2^W on overflow. The difference and the final sum are formed one bit wider, so they never wrap.
- R6: For even n, data_o = (y1[n-1] + C1) >>> 1. Here C1 = r + ((r − y1[n]) >>> 1), and r is the second-section state left by the previous even sample: r_new = y1[n] + ((r − y1[n]) >>> 1), wrapping as in R5.
- R7: data_o holds its last output value in every cycle where valid_o is low.
- R8: The output value and its latency do not depend on the spacing of valid_i pulses, including back-to-back input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i holds a sample this cycle |
| data_i | input | W | Input sample, two's complement |
| valid_o | output | 1 | One-cycle pulse marking a decimated output |
| data_o | output | W | Decimated filtered sample, two's complement |

## Verification
The bench builds the block at its default word length of 12 bits with two sections. At that width, full-scale inputs of opposite sign drive the adaptor sums past the signed range, so the modular wrap of R5 is exercised together with ordinary impulse and step responses. Random valid gaps, back-to-back bursts and a reset in mid-stream show that only accepted samples set the even/odd indexing, the state and the output timing.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_SEC = 2;  // cascaded sections
  localparam int SEC_LAT = 3;  // pipeline stages per section
  localparam int OUT_LAT = NUM_SEC * SEC_LAT;
endpackage

// File: rtl/hb_adaptor.sv
// Symmetric two-port adaptor with coefficient 1/2 (shift), W-bit wrapping ports.
module hb_adaptor #(
  parameter int W = 12
) (
  input  logic [W-1:0] a1_i,
  input  logic [W-1:0] a2_i,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  logic signed [W:0]   diff;
  logic        [W-1:0] half;

  assign diff = $signed({a2_i[W-1], a2_i}) - $signed({a1_i[W-1], a1_i});
  assign half = W'(diff >>> 1);
  assign b1_o = a2_i + half;
  assign b2_o = a1_i + half;
endmodule

// File: rtl/hb_section.sv
// One half-band section. EVEN_ONLY folds decimation in: only even samples
// enter the recursive part, and the delay shrinks to one entry.
module hb_section #(
  parameter int W         = 12,
  parameter bit EVEN_ONLY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int DEPTH = EVEN_ONLY ? 1 : 2;

  logic                  odd_q;
  logic [W-1:0]          prev_q;
  logic                  take;
  logic                  s1_v, s2_v;
  logic [W-1:0]          s1_x, s1_p, s2_p, s2_b1;
  logic [DEPTH-1:0][W-1:0] dly_q;
  logic [W-1:0]          b1, b2;
  logic signed [W:0]     sum;

  assign take = valid_i && (!EVEN_ONLY || !odd_q);

  // stage 1: capture sample and its predecessor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      prev_q <= '0;
      s1_v   <= 1'b0;
      s1_x   <= '0;
      s1_p   <= '0;
    end else begin
      s1_v <= take;
      if (valid_i) begin
        odd_q  <= ~odd_q;
        prev_q <= data_i;
      end
      if (take) begin
        s1_x <= data_i;
        s1_p <= prev_q;
      end
    end
  end

  hb_adaptor #(.W(W)) u_adp (
    .a1_i (s1_x),
    .a2_i (dly_q[DEPTH-1]),
    .b1_o (b1),
    .b2_o (b2)
  );

  // stage 2: adaptor and recursive delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      s2_v  <= 1'b0;
      s2_b1 <= '0;
      s2_p  <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        dly_q[0] <= b2;
        for (int i = 1; i < DEPTH; i++) dly_q[i] <= dly_q[i-1];
        s2_b1 <= b1;
        s2_p  <= s1_p;
      end
    end
  end

  // stage 3: average of direct and allpass branches
  assign sum = $signed({s2_p[W-1], s2_p}) + $signed({s2_b1[W-1], s2_b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= s2_v;
      if (s2_v) data_o <= W'(sum >>> 1);
    end
  end
endmodule

// File: rtl/hb_decim_top.sv
module hb_decim_top #(
  parameter int W       = 12,
  parameter int NUM_SEC = hb_pkg::NUM_SEC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [NUM_SEC:0]        v_c;
  logic [NUM_SEC:0][W-1:0] d_c;

  assign v_c[0] = valid_i;
  assign d_c[0] = data_i;

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    hb_section #(
      .W         (W),
      .EVEN_ONLY (g == NUM_SEC - 1)
    ) u_sec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (v_c[g]),
      .data_i  (d_c[g]),
      .valid_o (v_c[g+1]),
      .data_o  (d_c[g+1])
    );
  end

  assign valid_o = v_c[NUM_SEC];
  assign data_o  = d_c[NUM_SEC];
endmodule

// File: rtl/hb_decim_chk.sv
module hb_decim_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         valid_o,
  input logic [W-1:0] data_o
);
  localparam int LAT = hb_pkg::OUT_LAT;

  logic even_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      even_q <= 1'b1;
    else if (valid_i) even_q <= ~even_q;
  end

  // R2
  even_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && even_q) |-> ##LAT valid_o);

  // R2
  odd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !even_q) |-> ##LAT !valid_o);

  // R8
  out_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, LAT));

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind hb_decim_top hb_decim_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .data_o  (data_o)
);

// File: tb/sim_hb_decim_top.sv
`timescale 1ns/1ps
module sim_hb_decim_top;
  localparam int W   = 12;
  localparam int LAT = 5;  // output visible after edge acc+5

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_o;
  logic [W-1:0] data_o;

  always #2.5 clk = ~clk;

  hb_decim_top u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  typedef struct { int due; int val; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  int xprev, s1a, s1b, y1prev, s2, idx, last;
  int a1, a2, m, b1, b2, y1, o;
  bit finished = 1'b0;

  function automatic int wrapw(int v);
    int r = v & ((1 << W) - 1);
    if (r >= (1 << (W - 1))) r -= (1 << W);
    return r;
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return wrapw(int'(v));
  endfunction

  // behavioural reference, sample-indexed (R3: only accepted samples count)
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      xprev = 0; s1a = 0; s1b = 0; y1prev = 0; s2 = 0; idx = 0; last = 0;
      q.delete();
    end else begin
      cyc++;
      if (valid_i) begin
        a1 = sx(data_i); a2 = s1b;            // R4
        m  = (a2 - a1) >>> 1;
        b1 = wrapw(a2 + m); b2 = wrapw(a1 + m);  // R5
        s1b = s1a; s1a = b2;
        y1 = (xprev + b1) >>> 1;
        xprev = a1;
        if (idx % 2 == 0) begin               // R6
          m  = (s2 - y1) >>> 1;
          b1 = wrapw(s2 + m);
          s2 = wrapw(y1 + m);
          o  = (y1prev + b1) >>> 1;
          q.push_back('{due: cyc + LAT, val: o});
        end
        y1prev = y1;
        idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_ni) begin
        checks++;
        if (valid_o !== 1'b0 || data_o !== '0) begin
          fails++;
          $display("FAIL R1 valid_o=%0b data_o=%0d exp 0/0", valid_o, sx(data_o));
        end
      end else begin
        bit ev;
        ev = (q.size() > 0) && (q[0].due == cyc);
        checks++;
        if (valid_o !== ev) begin
          fails++;
          $display("FAIL R2 R8 cyc=%0d valid_o=%0b exp=%0b", cyc, valid_o, ev);
        end
        if (ev) begin
          checks++;
          if (sx(data_o) != q[0].val) begin
            fails++;
            $display("FAIL R4 R5 R6 cyc=%0d data_o=%0d exp=%0d", cyc, sx(data_o), q[0].val);
          end
          last = q[0].val;
          void'(q.pop_front());
        end else begin
          checks++;
          if (sx(data_o) != last) begin
            fails++;
            $display("FAIL R7 cyc=%0d data_o=%0d exp=%0d", cyc, sx(data_o), last);
          end
        end
      end
    end
  end

  task automatic send(input int v);
    @(negedge clk); #1;
    valid_i = 1'b1;
    data_i  = v[W-1:0];
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      valid_i = 1'b0;
      data_i  = W'($urandom);  // R3: garbage while idle
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    // impulse response
    send(1024);
    for (int i = 0; i < 30; i++) send(0);
    gap(3);
    // positive full-scale step, back-to-back (R8)
    for (int i = 0; i < 40; i++) send(2047);
    // negative full-scale step
    for (int i = 0; i < 40; i++) send(-2048);
    // alternating extremes: drives adaptor wrap (R5)
    for (int i = 0; i < 60; i++) send((i % 2) ? -2048 : 2047);
    for (int i = 0; i < 30; i++) send((i % 3 == 0) ? 2047 : -2048);
    // random data with random gaps (R3, R8)
    for (int i = 0; i < 800; i++) begin
      send(int'($urandom_range(0, 4095)) - 2048);
      if ($urandom_range(0, 9) < 4) gap(int'($urandom_range(1, 3)));
    end
    gap(10);
    // reset in mid-stream clears state and index (R1)
    for (int i = 0; i < 7; i++) send(1500 - 400 * i);
    do_reset();
    send(-1000);
    for (int i = 0; i < 20; i++) send(0);
    for (int i = 0; i < 600; i++) begin
      send(int'($urandom_range(0, 4095)) - 2048);
      if ($urandom_range(0, 9) < 2) gap(1);
    end
    gap(12);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule